// File: doc/BRIEF.md
# Two-Level Weighted Spare-Bandwidth Sharer

This block sits inside a memory bandwidth controller that is shared by several QoS register interfaces, each of which serves a small set of resource-control IDs (RCIDs). Each interface is given, exactly once after reset, a reserved bandwidth and a sharing weight through a reserve-limit operation. Each RCID has its own weight, which comes in as a configuration input.

At every accounting-interval boundary the block takes the amount of spare bandwidth and divides it in two stages. First it splits the amount among the contending interfaces in proportion to their weights. Then it splits each interface's portion among that interface's contending RCIDs in proportion to the RCID weights. The result is one grant of extra bandwidth units per (interface, RCID) pair. The grants are held until the next boundary.

An interface with weight zero keeps only its reservation and receives no spare bandwidth. Reserved amounts play no part in the split. Spare bandwidth therefore also reaches requesters that have already used up their reservation.

Top module: `bw_share_top`

## Requirements
- R1: An operation with `op_code` 4 (reserve) for an interface that has not been reserved yet succeeds. One cycle after `op_valid`, `op_done` is 1, `op_status` is 1, and the interface's `q_maxbw` field equals `op_rbwb`. `op_weight` becomes the interface weight.
- R2: A reserve operation for an interface that has already been reserved fails. `op_status` is 2, and the stored maximum bandwidth and weight do not change.
- R3: Any `op_code` other than 4, or an interface index out of range, gives `op_status` 3 and changes nothing. An interface rejected this way can still be reserved later.
- R4: An interface that has not been reserved, or whose weight is 0, gets a grant of 0 for all of its RCIDs.
- R5: An interface contends when it is reserved, its weight is non-zero, and it has at least one contending RCID. Its portion is floor(spare × weight / sum of the weights of all contending interfaces). Reserved amounts do not affect this portion.
- R6: An RCID contends when its `active` bit is 1 and its weight is non-zero. Its grant is floor(portion × RCID weight / sum of the contending RCID weights in its interface). RCIDs that do not contend get 0.
- R7: At each stage, the units lost to flooring go to the lowest-numbered contending entry. When any interface contends, the grants add up exactly to the spare amount. When none contends, every grant is 0.
- R8: The grants change only on the clock edge at which `interval_start` is 1, and they take their new values from that edge. At all other times they hold, whatever the inputs do.
- R9: After reset all grants are 0, every interface is unreserved, and `q_maxbw` is 0.

Grant `(q,r)` occupies bits `[(q*NR+r)*BW_W +: BW_W]` of `grant`. RCID weight `(q,r)` occupies bits `[(q*NR+r)*WT_W +: WT_W]` of `r_weight`. The `active` bit for `(q,r)` is bit `q*NR+r`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request strobe |
| op_code | input | 3 | Operation code; 4 = reserve |
| op_qrid | input | $clog2(NQ) | Target interface index |
| op_rbwb | input | BW_W | Reserved bandwidth for the interface |
| op_weight | input | WT_W | Sharing weight for the interface |
| op_done | output | 1 | Operation completed (one-cycle pulse) |
| op_status | output | 3 | 1 = success, 2 = already reserved, 3 = invalid |
| q_maxbw | output | NQ*BW_W | Maximum reservable bandwidth of each interface |
| interval_start | input | 1 | Accounting-interval boundary strobe |
| spare_bw | input | BW_W | Spare bandwidth to distribute |
| active | input | NQ*NR | Per-(interface, RCID) activity flags |
| r_weight | input | NQ*NR*WT_W | Per-(interface, RCID) weights |
| grant | output | NQ*NR*BW_W | Per-(interface, RCID) extra bandwidth grants |

## Verification
Operation results (`op_done`, `op_status`, `q_maxbw`) are registered once, so they are due on the first edge after the `op_valid` cycle. Grants are due on the first edge after the `interval_start` cycle.

The bench changes inputs on the falling edge and samples each result on the next falling edge, half a period after the edge that loads it. It then changes `spare_bw` without a boundary strobe, waits one more cycle, and samples again to confirm that the grants held.

The expected grants come from a two-stage floor-and-remainder model written in the bench. That model is checked over every activity pattern, several weight sets and several spare amounts.

// File: rtl/bw_share_pkg.sv
package bw_share_pkg;
  localparam logic [2:0] OPC_RESERVE = 3'd4;
  localparam logic [2:0] ST_OK       = 3'd1;
  localparam logic [2:0] ST_TWICE    = 3'd2;
  localparam logic [2:0] ST_BADOP    = 3'd3;

  // Floor of amt*w/total; zero when total is zero.
  // Operands must keep amt*w below 2^32.
  function automatic logic [31:0] weighted_part(input logic [31:0] amt,
                                                input logic [31:0] w,
                                                input logic [31:0] total);
    if (total == 32'd0) return 32'd0;
    return (amt * w) / total;
  endfunction
endpackage

// File: rtl/bw_reserve_regs.sv
module bw_reserve_regs
  import bw_share_pkg::*;
#(
  parameter int NQ   = 2,
  parameter int BW_W = 8,
  parameter int WT_W = 8,
  localparam int QW  = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [2:0]           op_code,
  input  logic [QW-1:0]        op_qrid,
  input  logic [BW_W-1:0]      op_rbwb,
  input  logic [WT_W-1:0]      op_weight,
  output logic                 op_done,
  output logic [2:0]           op_status,
  output logic [NQ-1:0]        q_cfg,
  output logic [NQ*BW_W-1:0]   q_rb_flat,
  output logic [NQ*WT_W-1:0]   q_wt_flat
);
  logic [BW_W-1:0] q_rb [NQ];
  logic [WT_W-1:0] q_wt [NQ];

  // Named events for the assertions.
  logic op_is_reserve;
  logic op_in_range;
  assign op_is_reserve = (op_code == OPC_RESERVE);
  assign op_in_range   = (32'(op_qrid) < NQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_done   <= 1'b0;
      op_status <= 3'd0;
      q_cfg     <= '0;
      for (int q = 0; q < NQ; q++) begin
        q_rb[q] <= '0;
        q_wt[q] <= '0;
      end
    end else begin
      op_done <= op_valid;
      if (op_valid) begin
        if (!op_is_reserve || !op_in_range) begin
          op_status <= ST_BADOP;
        end else if (q_cfg[op_qrid]) begin
          op_status <= ST_TWICE;
        end else begin
          op_status      <= ST_OK;
          q_cfg[op_qrid] <= 1'b1;
          q_rb[op_qrid]  <= op_rbwb;
          q_wt[op_qrid]  <= op_weight;
        end
      end
    end
  end

  for (genvar q = 0; q < NQ; q++) begin : g_flat
    assign q_rb_flat[q*BW_W +: BW_W] = q_rb[q];
    assign q_wt_flat[q*WT_W +: WT_W] = q_wt[q];

    assert_once_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_is_reserve && 32'(op_qrid) == q && q_cfg[q])
      |=> (op_status == ST_TWICE && $stable(q_rb[q]) && $stable(q_wt[q])));

    assert_reserve_loads_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_is_reserve && 32'(op_qrid) == q && !q_cfg[q])
      |=> (op_status == ST_OK && q_cfg[q] && q_rb[q] == $past(op_rbwb)));
  end

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> op_done);

  assert_badop_inert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_is_reserve) |=> (op_status == ST_BADOP && $stable(q_cfg)));
endmodule

// File: rtl/bw_weighted_split.sv
module bw_weighted_split
  import bw_share_pkg::*;
#(
  parameter int N  = 2,
  parameter int AW = 8,
  parameter int WW = 8
) (
  input  logic [AW-1:0]   amount,
  input  logic [N*WW-1:0] weight,
  input  logic [N-1:0]    elig,
  output logic [N*AW-1:0] share
);
  logic [31:0]   wsum;
  logic [AW-1:0] part [N];
  logic [AW-1:0] given;
  logic [AW-1:0] left;
  logic          found;

  always_comb begin
    wsum = 32'd0;
    for (int i = 0; i < N; i++)
      if (elig[i]) wsum = wsum + 32'(weight[i*WW +: WW]);

    given = '0;
    for (int i = 0; i < N; i++) begin
      part[i] = elig[i] ? AW'(weighted_part(32'(amount), 32'(weight[i*WW +: WW]), wsum))
                        : '0;
      given = given + part[i];
    end
    left = amount - given;

    // Flooring residue goes to the lowest-numbered eligible entry.
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && !found) begin
        part[i] = part[i] + left;
        found   = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    assign share[i*AW +: AW] = part[i];
  end
endmodule

// File: rtl/bw_share_top.sv
module bw_share_top
  import bw_share_pkg::*;
#(
  parameter int NQ   = 2,
  parameter int NR   = 2,
  parameter int BW_W = 8,
  parameter int WT_W = 8,
  localparam int QW  = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int NG  = NQ * NR
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic [2:0]           op_code,
  input  logic [QW-1:0]        op_qrid,
  input  logic [BW_W-1:0]      op_rbwb,
  input  logic [WT_W-1:0]      op_weight,
  output logic                 op_done,
  output logic [2:0]           op_status,
  output logic [NQ*BW_W-1:0]   q_maxbw,
  input  logic                 interval_start,
  input  logic [BW_W-1:0]      spare_bw,
  input  logic [NG-1:0]        active,
  input  logic [NG*WT_W-1:0]   r_weight,
  output logic [NG*BW_W-1:0]   grant
);
  logic [NQ-1:0]      q_cfg;
  logic [NQ*WT_W-1:0] q_wt;
  logic [NG-1:0]      r_elig;
  logic [NQ-1:0]      q_elig;
  logic [NQ*BW_W-1:0] q_share;
  logic [NG*BW_W-1:0] next_grant;
  logic [NG*BW_W-1:0] grant_q;
  logic [31:0]        grant_sum;

  bw_reserve_regs #(.NQ(NQ), .BW_W(BW_W), .WT_W(WT_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_qrid   (op_qrid),
    .op_rbwb   (op_rbwb),
    .op_weight (op_weight),
    .op_done   (op_done),
    .op_status (op_status),
    .q_cfg     (q_cfg),
    .q_rb_flat (q_maxbw),
    .q_wt_flat (q_wt)
  );

  for (genvar k = 0; k < NG; k++) begin : g_relig
    assign r_elig[k] = active[k] && (r_weight[k*WT_W +: WT_W] != '0);
  end

  for (genvar q = 0; q < NQ; q++) begin : g_qelig
    assign q_elig[q] = q_cfg[q] && (q_wt[q*WT_W +: WT_W] != '0) && (|r_elig[q*NR +: NR]);
  end

  // Stage 1: split across interfaces.
  bw_weighted_split #(.N(NQ), .AW(BW_W), .WW(WT_W)) u_lvl1 (
    .amount (spare_bw),
    .weight (q_wt),
    .elig   (q_elig),
    .share  (q_share)
  );

  // Stage 2: split each interface portion across its RCIDs.
  for (genvar q = 0; q < NQ; q++) begin : g_lvl2
    bw_weighted_split #(.N(NR), .AW(BW_W), .WW(WT_W)) u_split (
      .amount (q_share[q*BW_W +: BW_W]),
      .weight (r_weight[q*NR*WT_W +: NR*WT_W]),
      .elig   (r_elig[q*NR +: NR]),
      .share  (next_grant[q*NR*BW_W +: NR*BW_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              grant_q <= '0;
    else if (interval_start) grant_q <= next_grant;
  end
  assign grant = grant_q;

  always_comb begin
    grant_sum = 32'd0;
    for (int k = 0; k < NG; k++) grant_sum = grant_sum + 32'(grant_q[k*BW_W +: BW_W]);
  end

  assert_grant_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !interval_start |=> $stable(grant_q));

  assert_sum_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (interval_start && (|q_elig)) |=> (grant_sum == 32'($past(spare_bw))));

  assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (interval_start && !(|q_elig)) |=> (grant_sum == 32'd0));

  for (genvar q = 0; q < NQ; q++) begin : g_chk
    assert_no_spare_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (interval_start && !q_elig[q]) |=> (grant_q[q*NR*BW_W +: NR*BW_W] == '0));
  end
endmodule

// File: tb/sim_bw_share_top.sv
`timescale 1ns/1ps
module sim_bw_share_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [0:0]  op_qrid;
  logic [7:0]  op_rbwb;
  logic [7:0]  op_weight;
  logic        op_done;
  logic [2:0]  op_status;
  logic [15:0] q_maxbw;
  logic        interval_start;
  logic [7:0]  spare_bw;
  logic [3:0]  active;
  logic [31:0] r_weight;
  logic [31:0] grant;

  int m_rw [4];
  int m_qw [2];
  bit m_cfg [2];
  int exp_g [4];
  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  assign r_weight = {m_rw[3][7:0], m_rw[2][7:0], m_rw[1][7:0], m_rw[0][7:0]};

  bw_share_top u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_qrid(op_qrid), .op_rbwb(op_rbwb), .op_weight(op_weight),
    .op_done(op_done), .op_status(op_status), .q_maxbw(q_maxbw),
    .interval_start(interval_start), .spare_bw(spare_bw), .active(active),
    .r_weight(r_weight), .grant(grant)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; op_valid = 1'b0; op_code = 3'd0; op_qrid = 1'b0;
    op_rbwb = 8'd0; op_weight = 8'd0; interval_start = 1'b0; spare_bw = 8'd0;
    active = 4'd0;
    m_cfg[0] = 0; m_cfg[1] = 0; m_qw[0] = 0; m_qw[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_op(input int code, input int q, input int rb, input int w,
                       input int exp_st, input string req);
    op_valid = 1'b1; op_code = 3'(code); op_qrid = 1'(q);
    op_rbwb = 8'(rb); op_weight = 8'(w);
    @(negedge clk);
    op_valid = 1'b0;
    check({req, " op_done"}, int'(op_done), 1);
    check({req, " op_status"}, int'(op_status), exp_st);
    if (exp_st == 1) begin
      m_cfg[q] = 1; m_qw[q] = w;
    end
  endtask

  // Two-stage floor split with residue to the lowest contender (R5, R6, R7).
  task automatic calc_expected(input int spare);
    int  wsum, given, rsum, rgiven;
    int  qs [2];
    bit  qel [2];
    bit  rel [4];
    bit  found;
    for (int k = 0; k < 4; k++) begin
      rel[k] = active[k] && (m_rw[k] != 0);
      exp_g[k] = 0;
    end
    wsum = 0;
    for (int q = 0; q < 2; q++) begin
      qel[q] = m_cfg[q] && (m_qw[q] != 0) && (rel[2*q] || rel[2*q+1]);
      if (qel[q]) wsum += m_qw[q];
    end
    given = 0;
    for (int q = 0; q < 2; q++) begin
      qs[q] = qel[q] ? (spare * m_qw[q]) / wsum : 0;
      given += qs[q];
    end
    found = 0;
    for (int q = 0; q < 2; q++)
      if (qel[q] && !found) begin qs[q] += spare - given; found = 1; end
    for (int q = 0; q < 2; q++) begin
      rsum = 0; rgiven = 0;
      for (int r = 0; r < 2; r++) if (rel[2*q+r]) rsum += m_rw[2*q+r];
      for (int r = 0; r < 2; r++) begin
        exp_g[2*q+r] = (rel[2*q+r] && rsum != 0) ? (qs[q] * m_rw[2*q+r]) / rsum : 0;
        rgiven += exp_g[2*q+r];
      end
      found = 0;
      for (int r = 0; r < 2; r++)
        if (rel[2*q+r] && !found) begin exp_g[2*q+r] += qs[q] - rgiven; found = 1; end
    end
  endtask

  task automatic run_interval(input int spare, input int act_bits);
    int mism;
    spare_bw = 8'(spare); active = 4'(act_bits); interval_start = 1'b1;
    @(negedge clk);
    interval_start = 1'b0;
    calc_expected(spare);
    mism = 0;
    for (int k = 0; k < 4; k++)
      if (int'(grant[k*8 +: 8]) != exp_g[k]) mism++;
    n_vec++;
    if (mism != 0) begin
      n_bad++;
      $display("FAIL R5/R6/R7 spare=%0d act=%b: got %h expected %02h%02h%02h%02h",
               spare, act_bits, grant, exp_g[3][7:0], exp_g[2][7:0], exp_g[1][7:0], exp_g[0][7:0]);
    end
    // Inputs move without a boundary: grants must hold (R8).
    spare_bw = ~spare_bw; active = ~active;
    @(negedge clk);
    n_vec++;
    if (int'(grant[31:24]) != exp_g[3] || int'(grant[23:16]) != exp_g[2] ||
        int'(grant[15:8]) != exp_g[1] || int'(grant[7:0]) != exp_g[0]) begin
      n_bad++;
      $display("FAIL R8 hold: got %h expected %02h%02h%02h%02h", grant,
               exp_g[3][7:0], exp_g[2][7:0], exp_g[1][7:0], exp_g[0][7:0]);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int spares [5];
    int wsets [3][4];
    spares = '{0, 1, 5, 77, 255};
    wsets  = '{'{50, 25, 50, 25}, '{1, 0, 7, 7}, '{3, 200, 255, 1}};
    for (int k = 0; k < 4; k++) m_rw[k] = 50;
    do_reset();

    // R9: reset state.
    check("R9 grant", int'(grant), 0);
    check("R9 q_maxbw", int'(q_maxbw), 0);
    check("R9 op_done", int'(op_done), 0);

    // R4: unreserved interfaces get nothing.
    run_interval(50, 4'hF);
    check("R4 unreserved grant", int'(grant), 0);

    // R3: invalid op leaves interface 1 unreserved.
    do_op(5, 1, 33, 9, 3, "R3");
    check("R3 q_maxbw unchanged", int'(q_maxbw[15:8]), 0);

    // R1: reserve both interfaces.
    do_op(4, 1, 50, 16, 1, "R1");
    check("R1 q_maxbw[1]", int'(q_maxbw[15:8]), 50);
    do_op(4, 0, 100, 16, 1, "R1");
    check("R1 q_maxbw[0]", int'(q_maxbw[7:0]), 100);

    // R2: second reserve on interface 0 rejected; weight stays 16.
    do_op(4, 0, 7, 3, 2, "R2");
    check("R2 q_maxbw[0] kept", int'(q_maxbw[7:0]), 100);

    // R5/R6: equal interface weights with different reservations; 50:25 RCIDs.
    m_rw[0] = 50; m_rw[1] = 25; m_rw[2] = 50; m_rw[3] = 25;
    run_interval(90, 4'hF);
    check("R6 grant q0r0", int'(grant[7:0]), 30);
    check("R6 grant q0r1", int'(grant[15:8]), 15);
    check("R5 grant q1r0", int'(grant[23:16]), 30);
    check("R5 grant q1r1", int'(grant[31:24]), 15);

    // R7: residue to lowest contender; 7 split 16:16 then 50:25.
    run_interval(7, 4'hF);
    check("R7 grant q0r0", int'(grant[7:0]), 3);
    check("R7 grant q1r1", int'(grant[31:24]), 1);

    // Sweep over weight sets, activity patterns and spare amounts.
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 4; k++) m_rw[k] = wsets[s][k];
      for (int a = 0; a < 16; a++)
        for (int p = 0; p < 5; p++)
          run_interval(spares[p], a);
    end

    // R4: weight-zero interface is capped at its reservation.
    do_reset();
    for (int k = 0; k < 4; k++) m_rw[k] = 4 + k;
    do_op(4, 0, 40, 0, 1, "R1");
    do_op(4, 1, 10, 5, 1, "R1");
    for (int a = 0; a < 16; a++) begin
      run_interval(200, a);
      check("R4 zero-weight q0", int'(grant[15:0]), 0);
      run_interval(9, a);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule